// File: doc/BRIEF.md
# Host Buffer Data Port

This block gives a host processor one register address through which it streams bytes into a transmit buffer memory and out of a receive buffer memory. Each memory has its own pointer. A host write to the data port stores the bus data at the transmit pointer and moves that pointer on. A host read of the same address fetches from the receive pointer and moves the receive pointer on. The data reaches the host one cycle after the read strobe.

In byte mode the port uses the low byte lane only, and each access moves the pointer by one. In word mode the high lane of the port slot acts as a second byte register that carries the upper half of a 16-bit transfer. Each access then moves the pointer by two. A word-mode port access must enable both lanes. If one lane is missing, the access is dropped and a sticky error flag is set. The control, status and pointer registers accept full-word or single-lane access in either mode. Through the control register the host can clear each pointer on its own.

Top module: `hbport`

## Requirements
- R1: In byte mode, a port write with lane 0 enabled asserts `tx_we` with `tx_wide`=0, `tx_addr` equal to the transmit pointer and `tx_data[7:0]` equal to the low bus lane. The transmit pointer then grows by 1. The high lane is ignored.
- R2: In word mode, a port write with `host_be`=2'b11 asserts `tx_we` with `tx_wide`=1 and the full 16-bit bus word. The low byte belongs at `tx_addr` and the high byte at `tx_addr`+1. The transmit pointer then grows by 2.
- R3: A port read asserts `rx_re` at `rx_addr` equal to the receive pointer. The memory answers on `rx_data` one cycle later, with the byte at `rx_addr` in bits 7:0 and the byte at `rx_addr`+1 in bits 15:8. In that same cycle `host_rvalid` is 1 and `host_rdata` holds the read data: zero-extended bits 7:0 in byte mode, all 16 bits in word mode. The receive pointer grows by 1 in byte mode and by 2 in word mode.
- R4: In word mode, a port access whose `host_be` is not 2'b11 writes no memory, changes neither pointer and sets the error flag.
- R5: The error flag reads at slot 2 bit 0. Once set, it stays set until the host writes 1 to that bit with lane 0 enabled.
- R6: Writing control slot 1 with lane 1 enabled clears the transmit pointer when bit 8 is 1 and the receive pointer when bit 9 is 1. Each clear acts independently, and both bits read back as 0.
- R7: Slot 1 bit 0 is the word-mode bit, written only when lane 0 is enabled. On a register read, a lane that is not enabled returns 0.
- R8: The transmit pointer reads at slot 3 and the receive pointer at slot 4. Both are read-only. Pointers wrap modulo 2^PTR_W.
- R9: After reset both pointers are 0, the block is in byte mode, the error flag is 0 and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Bus cycle select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | ADDR_W | Register slot: 0 port, 1 control, 2 status, 3 tx pointer, 4 rx pointer |
| host_be | input | 2 | Byte lane enables, bit 0 low lane |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read strobe |
| tx_we | output | 1 | Transmit memory write strobe |
| tx_addr | output | PTR_W | Transmit byte address |
| tx_data | output | 16 | Transmit write data |
| tx_wide | output | 1 | Write two bytes rather than one |
| rx_re | output | 1 | Receive memory read strobe |
| rx_addr | output | PTR_W | Receive byte address |
| rx_wide | output | 1 | Two-byte read requested |
| rx_data | input | 16 | Receive memory data, one cycle after rx_re |

## Verification
The assertions assume that the host never raises the write and read strobes together, that each bus operation lasts exactly one cycle, and that the receive memory answers exactly one cycle after `rx_re`. The stimulus meets all three assumptions. Its tasks issue single-cycle operations one at a time with idle cycles between them, and the memory model in the stimulus registers its read data on the strobe edge. The stimulus uses a 4-bit pointer so that long sweeps cross the wrap boundary, and it computes every expected byte from the access sequence.

// File: rtl/hbport.sv
module hbport #(
  parameter int PTR_W  = 11,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_be,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_rvalid,
  output logic              tx_we,
  output logic [PTR_W-1:0]  tx_addr,
  output logic [15:0]       tx_data,
  output logic              tx_wide,
  output logic              rx_re,
  output logic [PTR_W-1:0]  rx_addr,
  output logic              rx_wide,
  input  logic [15:0]       rx_data
);
  localparam logic [ADDR_W-1:0] S_PORT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] S_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] S_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] S_TXP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] S_RXP  = ADDR_W'(4);

  logic [PTR_W-1:0] tx_ptr, rx_ptr;
  logic             word_mode, err_flag;
  logic             rd_q, port_q, wide_q;
  logic [15:0]      reg_q, reg_val;

  wire wr_cyc   = host_sel & host_wr;
  wire rd_cyc   = host_sel & host_rd;
  wire at_port  = host_addr == S_PORT;
  wire lanes_ok = word_mode ? (host_be == 2'b11) : host_be[0];
  wire port_wr  = wr_cyc & at_port & lanes_ok;
  wire port_rd  = rd_cyc & at_port & lanes_ok;
  wire port_bad = (wr_cyc | rd_cyc) & at_port & word_mode & (host_be != 2'b11);
  wire ctrl_hi  = wr_cyc & (host_addr == S_CTRL) & host_be[1];
  wire ctrl_lo  = wr_cyc & (host_addr == S_CTRL) & host_be[0];
  wire stat_lo  = wr_cyc & (host_addr == S_STAT) & host_be[0];
  wire [PTR_W-1:0] step = word_mode ? PTR_W'(2) : PTR_W'(1);

  assign tx_we   = port_wr;
  assign tx_addr = tx_ptr;
  assign tx_wide = word_mode;
  assign tx_data = word_mode ? host_wdata : {8'h00, host_wdata[7:0]};
  assign rx_re   = port_rd;
  assign rx_addr = rx_ptr;
  assign rx_wide = word_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ptr    <= '0;
      rx_ptr    <= '0;
      word_mode <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (ctrl_hi && host_wdata[8]) tx_ptr <= '0;
      else if (port_wr)             tx_ptr <= tx_ptr + step;
      if (ctrl_hi && host_wdata[9]) rx_ptr <= '0;
      else if (port_rd)             rx_ptr <= rx_ptr + step;
      if (ctrl_lo) word_mode <= host_wdata[0];
      if (port_bad)                     err_flag <= 1'b1;
      else if (stat_lo && host_wdata[0]) err_flag <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      S_CTRL:  reg_val = {15'd0, word_mode};
      S_STAT:  reg_val = {15'd0, err_flag};
      S_TXP:   reg_val = 16'(tx_ptr);
      S_RXP:   reg_val = 16'(rx_ptr);
      default: reg_val = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      port_q <= 1'b0;
      wide_q <= 1'b0;
      reg_q  <= '0;
    end else begin
      rd_q   <= rd_cyc;
      port_q <= port_rd;
      wide_q <= word_mode;
      reg_q  <= reg_val & {{8{host_be[1]}}, {8{host_be[0]}}};
    end
  end

  assign host_rvalid = rd_q;
  assign host_rdata  = !port_q ? reg_q : (wide_q ? rx_data : {8'h00, rx_data[7:0]});
endmodule

// File: rtl/hbport_chk.sv
module hbport_chk #(
  parameter int PTR_W  = 11,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [1:0]        host_be,
  input logic [15:0]       host_wdata,
  input logic              host_rvalid,
  input logic              tx_we,
  input logic [PTR_W-1:0]  tx_addr,
  input logic              tx_wide,
  input logic              rx_re,
  input logic [PTR_W-1:0]  rx_addr,
  input logic              rx_wide,
  input logic [PTR_W-1:0]  tx_ptr,
  input logic [PTR_W-1:0]  rx_ptr,
  input logic              word_mode,
  input logic              err_flag
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> !(host_wr && host_rd)); // R3
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> tx_ptr == $past(tx_addr) + ($past(tx_wide) ? PTR_W'(2) : PTR_W'(1))); // R1
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_re |=> rx_ptr == $past(rx_addr) + ($past(rx_wide) ? PTR_W'(2) : PTR_W'(1))); // R3
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_rd |=> host_rvalid); // R3
  AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && (host_wr || host_rd) && host_addr == ADDR_W'(0) && word_mode && host_be != 2'b11
    |=> err_flag && tx_ptr == $past(tx_ptr) && rx_ptr == $past(rx_ptr)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(host_sel && host_wr && host_addr == ADDR_W'(2) && host_be[0] && host_wdata[0])
    |=> err_flag); // R5
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_wr && host_addr == ADDR_W'(1) && host_be[1] && host_wdata[8]
    |=> tx_ptr == '0); // R6
endmodule

bind hbport hbport_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .tx_we(tx_we), .tx_addr(tx_addr), .tx_wide(tx_wide), .rx_re(rx_re), .rx_addr(rx_addr),
  .rx_wide(rx_wide), .tx_ptr(tx_ptr), .rx_ptr(rx_ptr), .word_mode(word_mode), .err_flag(err_flag));

// File: tb/test_hbport.sv
module test_hbport;
  localparam int PW = 4;
  localparam int DEPTH = 1 << PW;

  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [1:0] host_be = 0;
  logic [15:0] host_wdata = 0, host_rdata, tx_data;
  logic [15:0] rx_data = 0;
  logic host_rvalid, tx_we, tx_wide, rx_re, rx_wide;
  logic [PW-1:0] tx_addr, rx_addr;

  logic [7:0] txmem [DEPTH];
  logic [7:0] exp_tx [DEPTH];
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hbport #(.PTR_W(PW), .ADDR_W(3)) i_hbport (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .tx_we(tx_we), .tx_addr(tx_addr), .tx_data(tx_data), .tx_wide(tx_wide),
    .rx_re(rx_re), .rx_addr(rx_addr), .rx_wide(rx_wide), .rx_data(rx_data));

  function automatic logic [7:0] pat(int a);
    return 8'((a % DEPTH) * 37 + 5);
  endfunction

  always_ff @(posedge clk) begin
    if (tx_we) begin
      txmem[tx_addr] <= tx_data[7:0];
      if (tx_wide) txmem[PW'(tx_addr + 1)] <= tx_data[15:8];
    end
    if (rx_re) rx_data <= {pat(int'(rx_addr) + 1), pat(int'(rx_addr))};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_be = be; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0; host_be = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] be, output logic [15:0] d);
    host_sel = 1; host_rd = 1; host_addr = a; host_be = be;
    @(negedge clk);
    host_sel = 0; host_rd = 0; host_be = 0;
    chk("R3 rvalid", 32'(host_rvalid), 1);
    d = host_rdata;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int p;
    for (int i = 0; i < DEPTH; i++) begin txmem[i] = 8'hEE; exp_tx[i] = 8'hEE; end
    repeat (3) @(negedge clk);
    chk("R9 tx_we idle", 32'(tx_we), 0);
    chk("R9 rx_re idle", 32'(rx_re), 0);
    rst_n = 1;
    @(negedge clk);
    rd(3'd3, 2'b11, v); chk("R9 txptr", 32'(v), 0);
    rd(3'd4, 2'b11, v); chk("R9 rxptr", 32'(v), 0);
    rd(3'd1, 2'b11, v); chk("R9 mode", 32'(v), 0);
    rd(3'd2, 2'b11, v); chk("R9 err", 32'(v), 0);

    // R1 byte writes crossing the wrap
    for (int i = 0; i < 20; i++) begin
      wr(3'd0, 2'b11, {8'hAA, 8'(i * 11 + 1)});
      exp_tx[i % DEPTH] = 8'(i * 11 + 1);
    end
    for (int i = 0; i < DEPTH; i++) chk("R1 tx byte", 32'(txmem[i]), 32'(exp_tx[i]));
    rd(3'd3, 2'b11, v); chk("R8 txptr wrap", 32'(v), 32'(20 % DEPTH));

    // R3 byte reads
    for (int i = 0; i < 18; i++) begin
      rd(3'd0, 2'b01, v);
      chk("R3 byte read", 32'(v), {24'd0, pat(i)});
    end
    rd(3'd4, 2'b11, v); chk("R8 rxptr wrap", 32'(v), 32'(18 % DEPTH));

    // R7 lane writes; R6 independent clears
    wr(3'd1, 2'b10, 16'h0201);
    rd(3'd1, 2'b11, v); chk("R7 hi lane leaves mode", 32'(v), 0);
    rd(3'd3, 2'b11, v); chk("R6 tx kept", 32'(v), 32'(20 % DEPTH));
    rd(3'd4, 2'b11, v); chk("R6 rx cleared", 32'(v), 0);
    wr(3'd1, 2'b01, 16'h01FF);
    rd(3'd1, 2'b11, v); chk("R7 lo lane sets mode", 32'(v), 1);
    rd(3'd1, 2'b10, v); chk("R7 masked lane", 32'(v), 0);
    rd(3'd3, 2'b11, v); chk("R6 lo lane no clear", 32'(v), 32'(20 % DEPTH));
    wr(3'd1, 2'b11, 16'h0101);
    rd(3'd3, 2'b11, v); chk("R6 tx cleared", 32'(v), 0);

    // R2 word writes
    for (int i = 0; i < 10; i++) begin
      v = 16'(i * 4099 + 16'h1234);
      wr(3'd0, 2'b11, v);
      exp_tx[(2 * i) % DEPTH] = v[7:0];
      exp_tx[(2 * i + 1) % DEPTH] = v[15:8];
    end
    for (int i = 0; i < DEPTH; i++) chk("R2 tx word", 32'(txmem[i]), 32'(exp_tx[i]));
    rd(3'd3, 2'b11, v); chk("R2 txptr", 32'(v), 32'(20 % DEPTH));

    // R3 word reads
    for (int i = 0; i < 10; i++) begin
      p = 2 * i;
      rd(3'd0, 2'b11, v);
      chk("R3 word read", 32'(v), {16'd0, pat(p + 1), pat(p)});
    end
    rd(3'd4, 2'b11, v); chk("R3 rxptr", 32'(v), 32'(20 % DEPTH));

    // R4 partial port accesses in word mode
    wr(3'd0, 2'b01, 16'h5A5A);
    rd(3'd3, 2'b11, v); chk("R4 txptr hold", 32'(v), 32'(20 % DEPTH));
    for (int i = 0; i < DEPTH; i++) chk("R4 tx untouched", 32'(txmem[i]), 32'(exp_tx[i]));
    rd(3'd2, 2'b11, v); chk("R4 err set", 32'(v), 1);
    rd(3'd0, 2'b10, v);
    rd(3'd4, 2'b11, v); chk("R4 rxptr hold", 32'(v), 32'(20 % DEPTH));

    // R5 sticky, clear
    wr(3'd2, 2'b10, 16'h0101);
    rd(3'd2, 2'b11, v); chk("R5 sticky", 32'(v), 1);
    wr(3'd2, 2'b01, 16'h0001);
    rd(3'd2, 2'b11, v); chk("R5 cleared", 32'(v), 0);

    // R8 read-only pointers
    wr(3'd3, 2'b11, 16'h0009);
    wr(3'd4, 2'b11, 16'h0007);
    rd(3'd3, 2'b11, v); chk("R8 txptr ro", 32'(v), 32'(20 % DEPTH));
    rd(3'd4, 2'b11, v); chk("R8 rxptr ro", 32'(v), 32'(20 % DEPTH));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule